// File: doc/BRIEF.md
# Interrupt Channel Enable Register Bank

The block keeps one enable bit for each interrupt request channel and masks the raw request lines with it. A bus master changes the enables through two windows of word registers: a write-one-to-clear window that disables channels and a write-one-to-set window that enables them. Both windows read back the same live enable state. Changes through the bus are accepted only while the privilege flag is high.

Hardware can also enable channels through a per-channel set strobe vector. A clear from the bus beats any set of the same bit in the same cycle. The two lowest channels are hard-wired enabled. The block does no prioritisation, vectoring or acknowledge.

Top module: `irq_enable_bank`

## Requirements
- R1: After reset, channels 2 and up are disabled and channels 0 and 1 are enabled, so word 0 reads 0x00000003 and words 1 and 2 read 0.
- R2: A privileged write to the clear window at offset 0x40 + 4*k disables every channel 32*k+b for which data bit b is 1. Bits written as 0 keep their state.
- R3: A privileged write to the set window at offset 0x30 + 4*k enables every channel 32*k+b for which data bit b is 1. Bits written as 0 keep their state.
- R4: A read at either window offset for word k returns the enable bits of channels 32*k+31 down to 32*k, with 1 meaning enabled. The read is combinational on the address.
- R5: Channels 0 and 1 always read as 1 and always pass their request through. No write changes them.
- R6: A write with the privilege flag low changes no enable bit. Reads still return the enable state.
- R7: A 1 on set_hw_i[n] enables channel n at the next edge whatever the privilege flag is. A clear of the same bit in the same cycle wins, and the bit ends up 0.
- R8: req_o[n] equals req_i[n] AND the enable bit of channel n.
- R9: Any address other than the six window words, including an unaligned one, reads as 0, and a write there changes no state.
- R10: Every enable change becomes visible on rdata_o and req_o right after the rising clock edge that samples the write or the set strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the bus access |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | High when the access is made in privilege mode |
| rdata_o | output | 32 | Read data for addr_i |
| set_hw_i | input | 96 | Per-channel hardware enable strobe |
| req_i | input | 96 | Raw request lines |
| req_o | output | 96 | Requests masked by the enables |

## Verification
The bench builds the block with its default parameters: 96 channels in three 32-bit words, with the clear window at 0x40 and the set window at 0x30. With these values the last word is full and the hard-wired pair sits inside word 0, so one configuration covers both the partial always-on word and the full upper words. A behavioural model is updated on every edge and compares read data and masked requests on every cycle. The directed steps hit the clear-beats-set collision, user-mode writes, and the gaps and unaligned addresses next to the windows. A long random phase then mixes all of these.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 8;
  typedef logic [BUS_DW-1:0] bus_word_t;
endpackage

// File: rtl/irq_en_decode.sv
module irq_en_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned N_WORDS  = 3,
  parameter int unsigned CLR_BASE = 'h40,
  parameter int unsigned SET_BASE = 'h30,
  localparam int unsigned IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               priv_i,
  output logic [N_WORDS-1:0] clr_we_o,
  output logic [N_WORDS-1:0] set_we_o,
  output logic               rd_hit_o,
  output logic [IDX_W-1:0]   rd_idx_o
);
  logic [N_WORDS-1:0] clr_hit, set_hit;
  logic wr_ok;

  assign wr_ok = wr_i & priv_i;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign clr_hit[w]  = (addr_i == ADDR_W'(CLR_BASE + 4 * w));
    assign set_hit[w]  = (addr_i == ADDR_W'(SET_BASE + 4 * w));
    assign clr_we_o[w] = wr_ok & clr_hit[w];
    assign set_we_o[w] = wr_ok & set_hit[w];
  end

  assign rd_hit_o = |{clr_hit, set_hit};

  always_comb begin
    rd_idx_o = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (clr_hit[w] || set_hit[w]) rd_idx_o = IDX_W'(w);
    end
  end
endmodule

// File: rtl/irq_en_word.sv
module irq_en_word #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORD_IDX  = 0,
  parameter int unsigned NUM_CH    = 96,
  parameter int unsigned ALWAYS_ON = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] clr_i,
  input  logic [DATA_W-1:0] set_i,
  output logic [DATA_W-1:0] en_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int unsigned CH = WORD_IDX * DATA_W + b;
    if (CH < ALWAYS_ON) begin : g_on
      assign en_o[b] = 1'b1;
    end else if (CH >= NUM_CH) begin : g_pad
      assign en_o[b] = 1'b0;
    end else begin : g_ff
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       en_q <= 1'b0;
        else if (clr_i[b]) en_q <= 1'b0;   // clear beats set
        else if (set_i[b]) en_q <= 1'b1;
      end
      assign en_o[b] = en_q;

      a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i[b] |=> !en_o[b]);
      a_r3_set_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[b] && !clr_i[b]) |=> en_o[b]);
      a_r2_zero_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i[b] && !clr_i[b]) |=> $stable(en_o[b]));
    end
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int unsigned NUM_CH    = 96,
  parameter int unsigned ADDR_W    = irq_en_pkg::BUS_AW,
  parameter int unsigned DATA_W    = irq_en_pkg::BUS_DW,
  parameter int unsigned CLR_BASE  = 'h40,
  parameter int unsigned SET_BASE  = 'h30,
  parameter int unsigned ALWAYS_ON = 2,
  localparam int unsigned N_WORDS  = (NUM_CH + DATA_W - 1) / DATA_W,
  localparam int unsigned IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int unsigned PAD_W    = N_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] set_hw_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] req_o
);
  logic [N_WORDS-1:0] clr_we, set_we;
  logic               rd_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic [PAD_W-1:0]   en_pad, hw_pad;
  logic [N_WORDS-1:0][DATA_W-1:0] en_w;

  irq_en_decode #(
    .ADDR_W(ADDR_W), .N_WORDS(N_WORDS), .CLR_BASE(CLR_BASE), .SET_BASE(SET_BASE)
  ) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .priv_i(priv_i),
    .clr_we_o(clr_we), .set_we_o(set_we), .rd_hit_o(rd_hit), .rd_idx_o(rd_idx)
  );

  assign hw_pad = PAD_W'(set_hw_i);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] clr_m, set_m;
    assign clr_m = clr_we[w] ? wdata_i : '0;
    assign set_m = (set_we[w] ? wdata_i : '0) | hw_pad[w*DATA_W +: DATA_W];
    irq_en_word #(
      .DATA_W(DATA_W), .WORD_IDX(w), .NUM_CH(NUM_CH), .ALWAYS_ON(ALWAYS_ON)
    ) u_word (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_m), .set_i(set_m), .en_o(en_w[w])
    );
    assign en_pad[w*DATA_W +: DATA_W] = en_w[w];
  end

  assign rdata_o = rd_hit ? en_w[rd_idx] : '0;
  assign req_o   = req_i & en_pad[NUM_CH-1:0];

  a_r5_low_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[ALWAYS_ON-1:0] == req_i[ALWAYS_ON-1:0]);
  a_r5_low_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CLR_BASE)) |-> (rdata_o[ALWAYS_ON-1:0] == '1));
  a_r8_mask_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o & ~req_i) == '0);
  a_r6_user_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !priv_i && set_hw_i == '0) |=> $stable(en_pad));
  a_r9_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_hit && set_hw_i == '0) |=> $stable(en_pad));
endmodule

// File: tb/tb_irq_enable_bank.sv
module tb_irq_enable_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h40;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        priv = 1'b0;
  logic [31:0] rdata;
  logic [95:0] set_hw = '0;
  logic [95:0] req_in = '0;
  logic [95:0] req_out;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  logic [95:0] en_m;

  always #4 clk = ~clk;

  irq_enable_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .priv_i(priv), .rdata_o(rdata), .set_hw_i(set_hw), .req_i(req_in), .req_o(req_out)
  );

  function automatic int widx(logic [7:0] a, int base);
    for (int k = 0; k < 3; k++) if (a == 8'(base + 4 * k)) return k;
    return -1;
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    int k = widx(a, 'h40);
    if (k < 0) k = widx(a, 'h30);
    if (k < 0) return '0;
    return en_m[k*32 +: 32];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_m <= 96'h3;
    else begin
      logic [95:0] nxt;
      int ks, kc;
      nxt = en_m | set_hw;
      ks = widx(addr, 'h30);
      kc = widx(addr, 'h40);
      if (wr && priv && ks >= 0) nxt[ks*32 +: 32] = nxt[ks*32 +: 32] | wdata;
      if (wr && priv && kc >= 0) nxt[kc*32 +: 32] = nxt[kc*32 +: 32] & ~wdata;
      nxt[1:0] = 2'b11;
      en_m <= nxt;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rdata !== mread(addr)) begin
      errors++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", phase, addr, rdata, mread(addr));
    end
    checks++;
    if (req_out !== (req_in & en_m)) begin
      errors++;
      $display("FAIL R8 req_o actual=%h expected=%h", req_out, req_in & en_m);
    end
  end

  task automatic cyc(logic [7:0] a, logic w, logic [31:0] d, logic p, logic [95:0] hs);
    @(posedge clk); #1;
    addr = a; wr = w; wdata = d; priv = p; set_hw = hs;
    req_in = {$urandom, $urandom, $urandom};
  endtask

  initial begin
    // R1 reset state
    cyc(8'h40, 0, 0, 1, '0); cyc(8'h44, 0, 0, 1, '0); cyc(8'h48, 0, 0, 1, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc(8'h40, 0, 0, 1, '0); cyc(8'h34, 0, 0, 1, '0);
    phase = "R3";
    cyc(8'h30, 1, 32'hffff_ffff, 1, '0); cyc(8'h34, 1, 32'h8000_0001, 1, '0);
    cyc(8'h38, 1, 32'h0000_f0f0, 1, '0); cyc(8'h40, 0, 0, 1, '0);
    phase = "R2";
    cyc(8'h40, 1, 32'h0000_ff00, 1, '0); cyc(8'h48, 1, 32'h0, 1, '0);
    cyc(8'h48, 1, 32'h0000_0030, 1, '0); cyc(8'h48, 0, 0, 1, '0);
    phase = "R5";
    cyc(8'h40, 1, 32'hffff_ffff, 1, '0); cyc(8'h40, 0, 0, 1, '0);
    cyc(8'h30, 1, 32'h0000_0003, 1, '0); cyc(8'h40, 0, 0, 0, '0);
    phase = "R6";
    cyc(8'h30, 1, 32'hffff_ffff, 0, '0); cyc(8'h44, 1, 32'hffff_ffff, 0, '0);
    cyc(8'h44, 0, 0, 0, '0); cyc(8'h30, 0, 0, 0, '0);
    phase = "R7";
    cyc(8'h00, 0, 0, 0, 96'h20 | (96'h1 << 70)); cyc(8'h40, 0, 0, 0, '0);
    cyc(8'h40, 1, 32'h20, 1, 96'h20); cyc(8'h40, 0, 0, 1, '0);
    cyc(8'h48, 1, 32'h40, 1, 96'h1 << 70); cyc(8'h48, 0, 0, 1, '0);
    phase = "R9";
    cyc(8'h4c, 1, 32'hffff_ffff, 1, '0); cyc(8'h3c, 1, 32'hffff_ffff, 1, '0);
    cyc(8'h42, 1, 32'hffff_ffff, 1, '0); cyc(8'h31, 1, 32'hffff_ffff, 1, '0);
    cyc(8'h2c, 0, 0, 1, '0); cyc(8'h40, 0, 0, 1, '0); cyc(8'h34, 0, 0, 1, '0);
    phase = "R4";
    for (int i = 0; i < 6; i++) cyc(i < 3 ? 8'(8'h30 + 4 * i) : 8'(8'h40 + 4 * (i - 3)), 0, 0, 1, '0);
    phase = "R10";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [95:0] hs;
      case ($urandom_range(0, 3))
        0: a = 8'(8'h30 + 4 * $urandom_range(0, 2));
        1, 2: a = 8'(8'h40 + 4 * $urandom_range(0, 2));
        default: a = 8'($urandom);
      endcase
      hs = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom, $urandom} : '0;
      cyc(a, 1'($urandom), $urandom & $urandom, ($urandom_range(0, 3) != 0), hs);
    end
    cyc(8'h40, 0, 0, 1, '0);
    @(posedge clk); @(negedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule